// File: doc/BRIEF.md
# Prioritized Preemptive Packet Link Multiplexer

This block merges several message sources onto one shared point-to-point link. Each source offers a message of a stated length, a priority and a class (control or data) on a valid/ready word stream. The block cuts every message into packets. Each packet on the link is one header word followed by its payload words. Because packets have a bounded size, no single message can occupy the link for long.

Every packet boundary is an arbitration point. The link goes to the pending source with the highest priority. Among sources of equal priority, the grant rotates. A lower-priority message that is only partly sent keeps a per-source count of its unsent words, so it can be preempted by a more urgent message and resumed later at its next word. Control packets carry a fixed payload size. For data packets, the size limit comes from a runtime setting that is read only when a packet starts.

Top module: `pkt_link_mux`

## Requirements
- R1: After reset, `m_valid` is 0 and every bit of `s_ready` is 0 until a message is offered.
- R2: A header word is marked by `m_hdr`=1. Its bits [1:0] hold the source index, [3:2] the message priority, [7:4] the payload length of this packet, bit 8 is set on the last packet of a message, and bit 9 is set for a control-class message.
- R3: The payload length of each packet is the smaller of the words left in the message and the class limit. The class limit is CTRL_LEN (2) for control messages and `cfg_max_pay` for data messages. The last flag is set only on the packet that ends the message.
- R4: At a packet boundary the link is granted to a pending source whose priority value is the highest (larger value means more urgent).
- R5: A higher-priority message that arrives while a lower-priority message is in progress is sent after the current packet completes. The interrupted message then resumes with its next unsent word.
- R6: A header is followed by exactly as many payload words as its length field, all from the same source, in message order, with no other word interleaved.
- R7: Sources of equal priority that are pending together receive packets in rotating order, so no source gets two packets in a row while another of the same priority waits.
- R8: While `m_valid`=1 and `m_ready`=0, `m_valid` and `m_data` hold. A source sees `s_ready`=1 only while it owns the packet in progress.
- R9: `cfg_max_pay` is read only when a packet header is issued, so a change during a packet affects later packets only. A value of 0 acts as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_max_pay | input | PKT_W | Data-packet payload limit, 0 treated as 1 |
| s_valid | input | NSRC | Per-source word valid |
| s_ready | output | NSRC | Per-source word accepted |
| s_data | input | NSRC*DW | Per-source payload word |
| s_len | input | NSRC*LEN_W | Per-source message length in words, held for the whole message |
| s_prio | input | NSRC*PRIO_W | Per-source message priority, held for the whole message |
| s_ctrl | input | NSRC | Per-source class, 1 for control |
| m_valid | output | 1 | Link word valid |
| m_ready | input | 1 | Link ready |
| m_data | output | DW | Link word, header or payload |
| m_hdr | output | 1 | Marks the current link word as a header |

## Verification
The hardest case to reach from the ports is preemption in the middle of a message. The urgent request has to arrive while a lower-priority packet is partly sent, and it must not be seen before that packet's boundary. The bench starts a long low-priority message and waits until its first header appears on the link. Only then does it offer the urgent message, so the request lands inside the payload of the first packet. The bench then checks that the long message continues with the correct word index after the urgent packet. The runtime limit change uses the same timing, so that the first packet keeps its old length.

// File: rtl/pkt_link_mux_pkg.sv
package pkt_link_mux_pkg;

  typedef enum logic {ST_ARB = 1'b0, ST_PAY = 1'b1} mux_state_e;

  // Header layout, LSB first: source, priority, payload length, last, control.
  function automatic logic [31:0] pack_hdr(
    input int unsigned src, input int unsigned src_w,
    input int unsigned prio, input int unsigned prio_w,
    input int unsigned plen, input int unsigned plen_w,
    input logic last, input logic ctrl);
    logic [31:0] w;
    w = 32'(src);
    w = w | (32'(prio) << src_w);
    w = w | (32'(plen) << (src_w + prio_w));
    w = w | (32'(last) << (src_w + prio_w + plen_w));
    w = w | (32'(ctrl) << (src_w + prio_w + plen_w + 1));
    return w;
  endfunction

endpackage

// File: rtl/pkt_link_mux_ctx.sv
module pkt_link_mux_ctx #(
  parameter int LEN_W  = 8,
  parameter int PRIO_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [LEN_W-1:0]  in_len,
  input  logic [PRIO_W-1:0] in_prio,
  input  logic              in_ctrl,
  input  logic              load,
  input  logic              dec,
  output logic              pending,
  output logic [LEN_W-1:0]  eff_len,
  output logic [PRIO_W-1:0] eff_prio,
  output logic              eff_ctrl
);
  logic [LEN_W-1:0]  rem_q;
  logic [PRIO_W-1:0] prio_q;
  logic              ctrl_q;
  logic              active;

  assign active   = (rem_q != '0);
  assign pending  = active || (in_valid && (in_len != '0));
  assign eff_len  = active ? rem_q  : in_len;
  assign eff_prio = active ? prio_q : in_prio;
  assign eff_ctrl = active ? ctrl_q : in_ctrl;

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q  <= '0;
      prio_q <= '0;
      ctrl_q <= 1'b0;
    end else if (load) begin
      rem_q  <= eff_len;
      prio_q <= eff_prio;
      ctrl_q <= eff_ctrl;
    end else if (dec) begin
      rem_q <= rem_q - 1'b1;
    end
  end

  // R3: a word is only taken while the message still has words left
  p_dec_live_r3: assert property (@(posedge clk) disable iff (rst)
    dec |-> (rem_q != '0));

  // R5: a resumed message keeps its latched priority until it ends
  p_prio_keep_r5: assert property (@(posedge clk) disable iff (rst)
    (active && !load) |=> (rem_q == '0) || $stable(prio_q));

endmodule

// File: rtl/pkt_link_mux_arb.sv
module pkt_link_mux_arb #(
  parameter int NSRC   = 4,
  parameter int PRIO_W = 2,
  localparam int SRC_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic [NSRC-1:0]        pending,
  input  logic [NSRC*PRIO_W-1:0] prio,
  input  logic [SRC_W-1:0]       last,
  output logic                   gnt_valid,
  output logic [SRC_W-1:0]       gnt_idx
);
  logic [PRIO_W-1:0] top_p;

  always_comb begin
    top_p     = '0;
    gnt_valid = 1'b0;
    gnt_idx   = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (pending[i] && (!gnt_valid || prio[i*PRIO_W +: PRIO_W] > top_p)) begin
        top_p     = prio[i*PRIO_W +: PRIO_W];
        gnt_valid = 1'b1;
      end
    end
    // rotate among the winners, starting after the last grant
    for (int k = NSRC; k >= 1; k--) begin
      int unsigned j;
      j = 32'(last) + 32'(k);
      if (j >= 32'(NSRC)) j = j - 32'(NSRC);
      if (pending[j] && prio[j*PRIO_W +: PRIO_W] == top_p) gnt_idx = SRC_W'(j);
    end
  end

endmodule

// File: rtl/pkt_link_mux.sv
module pkt_link_mux #(
  parameter int NSRC     = 4,
  parameter int DW       = 16,
  parameter int PRIO_W   = 2,
  parameter int LEN_W    = 8,
  parameter int PKT_W    = 4,
  parameter int CTRL_LEN = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [PKT_W-1:0]        cfg_max_pay,
  input  logic [NSRC-1:0]         s_valid,
  output logic [NSRC-1:0]         s_ready,
  input  logic [NSRC*DW-1:0]      s_data,
  input  logic [NSRC*LEN_W-1:0]   s_len,
  input  logic [NSRC*PRIO_W-1:0]  s_prio,
  input  logic [NSRC-1:0]         s_ctrl,
  output logic                    m_valid,
  input  logic                    m_ready,
  output logic [DW-1:0]           m_data,
  output logic                    m_hdr
);
  import pkt_link_mux_pkg::*;

  localparam int SRC_W = (NSRC > 1) ? $clog2(NSRC) : 1;
  localparam int LEN_LSB = SRC_W + PRIO_W;

  mux_state_e             st_q;
  logic [SRC_W-1:0]       cur_q, last_q, gnt_idx;
  logic [PKT_W-1:0]       left_q;
  logic                   gnt_valid, slot_free, start_pkt, take;
  logic [NSRC-1:0]        pend, ctx_ctrl, load_v, dec_v;
  logic [NSRC*LEN_W-1:0]  ctx_len;
  logic [NSRC*PRIO_W-1:0] ctx_prio;
  logic [LEN_W-1:0]       g_len;
  logic                   g_ctrl, g_last;
  int unsigned            cap_i, pay_i;
  logic [DW-1:0]          hdr_word;

  for (genvar g = 0; g < NSRC; g++) begin : g_ctx
    pkt_link_mux_ctx #(.LEN_W(LEN_W), .PRIO_W(PRIO_W)) u_ctx (
      .clk     (clk),
      .rst     (rst),
      .in_valid(s_valid[g]),
      .in_len  (s_len[g*LEN_W +: LEN_W]),
      .in_prio (s_prio[g*PRIO_W +: PRIO_W]),
      .in_ctrl (s_ctrl[g]),
      .load    (load_v[g]),
      .dec     (dec_v[g]),
      .pending (pend[g]),
      .eff_len (ctx_len[g*LEN_W +: LEN_W]),
      .eff_prio(ctx_prio[g*PRIO_W +: PRIO_W]),
      .eff_ctrl(ctx_ctrl[g])
    );
  end

  pkt_link_mux_arb #(.NSRC(NSRC), .PRIO_W(PRIO_W)) u_arb (
    .pending  (pend),
    .prio     (ctx_prio),
    .last     (last_q),
    .gnt_valid(gnt_valid),
    .gnt_idx  (gnt_idx)
  );

  assign slot_free = !m_valid || m_ready;
  assign start_pkt = (st_q == ST_ARB) && slot_free && gnt_valid;

  always_comb begin
    s_ready = '0;
    if (st_q == ST_PAY && slot_free) s_ready[cur_q] = 1'b1;
  end
  assign take = |(s_ready & s_valid);

  always_comb begin
    load_v = '0;
    dec_v  = '0;
    if (start_pkt) load_v[gnt_idx] = 1'b1;
    if (take) dec_v[cur_q] = 1'b1;
  end

  // packet sizing: class limit, then clip to the words left
  always_comb begin
    g_len  = ctx_len[gnt_idx*LEN_W +: LEN_W];
    g_ctrl = ctx_ctrl[gnt_idx];
    if (g_ctrl) cap_i = 32'(CTRL_LEN);
    else if (cfg_max_pay == '0) cap_i = 32'd1;
    else cap_i = 32'(cfg_max_pay);
    pay_i  = (32'(g_len) < cap_i) ? 32'(g_len) : cap_i;
    g_last = (pay_i == 32'(g_len));
    hdr_word = DW'(pack_hdr(32'(gnt_idx), SRC_W,
                            32'(ctx_prio[gnt_idx*PRIO_W +: PRIO_W]), PRIO_W,
                            pay_i, PKT_W, g_last, g_ctrl));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_ARB;
      m_valid <= 1'b0;
      m_hdr   <= 1'b0;
      m_data  <= '0;
      cur_q   <= '0;
      last_q  <= SRC_W'(NSRC - 1);
      left_q  <= '0;
    end else begin
      case (st_q)
        ST_ARB: begin
          if (start_pkt) begin
            m_valid <= 1'b1;
            m_hdr   <= 1'b1;
            m_data  <= hdr_word;
            cur_q   <= gnt_idx;
            last_q  <= gnt_idx;
            left_q  <= PKT_W'(pay_i);
            st_q    <= ST_PAY;
          end else if (slot_free) begin
            m_valid <= 1'b0;
          end
        end
        default: begin
          if (take) begin
            m_valid <= 1'b1;
            m_hdr   <= 1'b0;
            m_data  <= s_data[cur_q*DW +: DW];
            left_q  <= left_q - 1'b1;
            if (left_q == PKT_W'(1)) st_q <= ST_ARB;
          end else if (slot_free) begin
            m_valid <= 1'b0;
          end
        end
      endcase
    end
  end

  // ---------------- assertions ----------------
  logic prio_ok;
  always_comb begin
    prio_ok = 1'b1;
    for (int i = 0; i < NSRC; i++)
      if (pend[i] && ctx_prio[i*PRIO_W +: PRIO_W] > ctx_prio[gnt_idx*PRIO_W +: PRIO_W])
        prio_ok = 1'b0;
  end

  p_grant_top_r4: assert property (@(posedge clk) disable iff (rst)
    start_pkt |-> prio_ok);

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (m_valid && !m_ready) |=> m_valid && $stable(m_data) && $stable(m_hdr));

  p_ready_owner_r8: assert property (@(posedge clk) disable iff (rst)
    (|s_ready) |-> pend[cur_q]);

  p_pay_nonzero_r9: assert property (@(posedge clk) disable iff (rst)
    start_pkt |=> m_hdr && (m_data[LEN_LSB +: PKT_W] != '0));

  p_count_live_r6: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_PAY) |-> (left_q != '0));

endmodule

// File: tb/pkt_link_mux_bench.sv
`timescale 1ns/1ps
module pkt_link_mux_bench;
  localparam int NSRC = 4, DW = 16, PRIO_W = 2, LEN_W = 8, PKT_W = 4, CTRL_LEN = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic [PKT_W-1:0]       cfg_max_pay;
  logic [NSRC-1:0]        s_valid, s_ready, s_ctrl;
  logic [NSRC*DW-1:0]     s_data;
  logic [NSRC*LEN_W-1:0]  s_len;
  logic [NSRC*PRIO_W-1:0] s_prio;
  logic                   m_valid, m_ready, m_hdr;
  logic [DW-1:0]          m_data;

  pkt_link_mux #(.NSRC(NSRC), .DW(DW), .PRIO_W(PRIO_W), .LEN_W(LEN_W),
                 .PKT_W(PKT_W), .CTRL_LEN(CTRL_LEN)) u_pkt_link_mux (
    .clk(clk), .rst(rst), .cfg_max_pay(cfg_max_pay),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .s_len(s_len),
    .s_prio(s_prio), .s_ctrl(s_ctrl),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_hdr(m_hdr));

  int nchk = 0, nerr = 0;
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // ---- message requests (main) and per-source drivers ----
  int msg_len[NSRC], msg_prio[NSRC], msg_ctrl[NSRC], tok[NSRC];
  logic dv[NSRC], dc[NSRC], busy[NSRC];
  logic [DW-1:0] dd[NSRC];
  logic [LEN_W-1:0] dl[NSRC];
  logic [PRIO_W-1:0] dp[NSRC];

  always_comb
    for (int i = 0; i < NSRC; i++) begin
      s_valid[i] = dv[i];
      s_ctrl[i]  = dc[i];
      s_data[i*DW +: DW] = dd[i];
      s_len[i*LEN_W +: LEN_W] = dl[i];
      s_prio[i*PRIO_W +: PRIO_W] = dp[i];
    end

  for (genvar gi = 0; gi < NSRC; gi++) begin : g_drv
    initial begin
      int seen, idx;
      logic hs;
      seen = 0; idx = 0;
      dv[gi] = 1'b0; dc[gi] = 1'b0; busy[gi] = 1'b0;
      dd[gi] = '0; dl[gi] = '0; dp[gi] = '0;
      forever begin
        @(negedge clk);
        hs = dv[gi] && s_ready[gi];
        @(posedge clk); #1;
        if (hs) begin
          idx++;
          if (idx == int'(dl[gi])) begin
            dv[gi] = 1'b0; busy[gi] = 1'b0;
          end else dd[gi] = DW'((gi << 8) | idx);
        end
        if (!busy[gi] && tok[gi] != seen) begin
          seen = tok[gi]; idx = 0; busy[gi] = 1'b1;
          dl[gi] = LEN_W'(msg_len[gi]); dp[gi] = PRIO_W'(msg_prio[gi]);
          dc[gi] = msg_ctrl[gi][0];
          dd[gi] = DW'(gi << 8); dv[gi] = 1'b1;
        end
      end
    end
  end

  // ---- link ready driver ----
  logic bp_mode = 1'b0;
  initial begin
    logic [7:0] lf;
    lf = 8'hA5; m_ready = 1'b1;
    forever begin
      @(posedge clk); #1;
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      m_ready = bp_mode ? lf[0] : 1'b1;
    end
  end

  // ---- capture monitor ----
  logic [DW-1:0] cap_d[256];
  logic cap_h[256];
  int ncap = 0, stall_err = 0, ready_err = 0;
  logic prev_stall = 1'b0;
  logic [DW-1:0] prev_d;
  always @(negedge clk) begin
    if (!rst) begin
      if (prev_stall && (!m_valid || m_data != prev_d)) stall_err++;
      if ($countones(s_ready) > 1) ready_err++;
      for (int i = 0; i < NSRC; i++) if (s_ready[i] && !busy[i]) ready_err++;
      if (m_valid && m_ready && ncap < 256) begin
        cap_d[ncap] = m_data; cap_h[ncap] = m_hdr; ncap++;
      end
      prev_stall = m_valid && !m_ready;
      prev_d = m_data;
    end
  end

  // ---- parsing of captured traffic ----
  int hsrc[32], hprio[32], hlen[32], hlast[32], hctrl[32];
  int nh, pay_err;
  task automatic parse();
    int nxt[NSRC];
    int cur, left;
    for (int i = 0; i < NSRC; i++) nxt[i] = 0;
    nh = 0; pay_err = 0; cur = 0; left = 0;
    for (int k = 0; k < ncap; k++) begin
      if (cap_h[k]) begin
        if (left != 0) pay_err++;
        if (nh < 32) begin
          hsrc[nh] = int'(cap_d[k][1:0]); hprio[nh] = int'(cap_d[k][3:2]);
          hlen[nh] = int'(cap_d[k][7:4]); hlast[nh] = int'(cap_d[k][8]);
          hctrl[nh] = int'(cap_d[k][9]);
        end
        cur = int'(cap_d[k][1:0]); left = int'(cap_d[k][7:4]); nh++;
      end else if (left == 0) pay_err++;
      else begin
        if (cap_d[k] != DW'((cur << 8) | nxt[cur])) pay_err++;
        nxt[cur]++; left--;
      end
    end
    if (left != 0) pay_err++;
  endtask

  task automatic send(input int s, input int len, input int pr, input int ct);
    msg_len[s] = len; msg_prio[s] = pr; msg_ctrl[s] = ct; tok[s]++;
  endtask

  task automatic wait_idle();
    repeat (3) @(posedge clk);
    while (busy[0] || busy[1] || busy[2] || busy[3]) @(posedge clk);
    repeat (20) @(posedge clk);
  endtask

  // src, len, prio, ctrl, cfg
  localparam int TAB[7][5] = '{
    '{0, 5, 1, 0, 4}, '{1, 8, 2, 0, 4}, '{2, 3, 0, 0, 8}, '{3, 5, 3, 1, 8},
    '{1, 3, 0, 0, 0}, '{2, 1, 1, 1, 15}, '{0, 17, 2, 0, 15}};

  initial begin
    for (int i = 0; i < NSRC; i++) begin
      tok[i] = 0; msg_len[i] = 0; msg_prio[i] = 0; msg_ctrl[i] = 0;
    end
    cfg_max_pay = 4'd4;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    repeat (2) @(negedge clk);
    chk(m_valid == 1'b0, "R1 m_valid after reset", int'(m_valid), 0);
    chk(s_ready == '0, "R1 s_ready after reset", int'(s_ready), 0);

    // table walk: one message at a time
    foreach (TAB[r]) begin
      int s, len, cap, rem, exp_n, bad;
      s = TAB[r][0]; len = TAB[r][1];
      cap = TAB[r][3] != 0 ? CTRL_LEN : (TAB[r][4] == 0 ? 1 : TAB[r][4]);
      exp_n = (len + cap - 1) / cap;
      cfg_max_pay = PKT_W'(TAB[r][4]);
      ncap = 0;
      send(s, len, TAB[r][2], TAB[r][3]);
      wait_idle();
      parse();
      chk(nh == exp_n, "R3 packet count", nh, exp_n);
      bad = 0; rem = len;
      for (int h = 0; h < nh && h < 32; h++) begin
        int p;
        p = rem < cap ? rem : cap;
        if (hlen[h] != p) bad++;
        if (hlast[h] != ((rem == p) ? 1 : 0)) bad++;
        rem -= p;
      end
      chk(bad == 0, "R3 lengths and last flag", bad, 0);
      bad = 0;
      for (int h = 0; h < nh && h < 32; h++)
        if (hsrc[h] != s || hprio[h] != TAB[r][2] || hctrl[h] != TAB[r][3]) bad++;
      chk(bad == 0, "R2 header fields", bad, 0);
      chk(pay_err == 0, "R6 payload order", pay_err, 0);
    end

    // R4: two sources offered together
    cfg_max_pay = 4'd4; ncap = 0;
    send(0, 3, 1, 0); send(2, 3, 3, 0);
    wait_idle(); parse();
    chk(nh == 2 && hsrc[0] == 2, "R4 higher priority first", hsrc[0], 2);
    chk(pay_err == 0, "R6 payload after priority", pay_err, 0);

    // R5: preemption mid-message, then resume
    ncap = 0;
    send(1, 12, 0, 0);
    while (ncap < 1) @(negedge clk);
    send(3, 2, 2, 0);
    wait_idle(); parse();
    chk(nh == 4 && hsrc[0] == 1 && hsrc[1] == 3 && hsrc[2] == 1 && hsrc[3] == 1,
        "R5 preempt order src of 2nd header", hsrc[1], 3);
    chk(hlen[0] == 4 && hlen[1] == 2 && hlen[2] == 4 && hlast[1] == 1 && hlast[0] == 0,
        "R5 first packet completed", hlen[0], 4);
    chk(pay_err == 0, "R5 resume at next unsent word", pay_err, 0);

    // R7: three equal-priority sources
    cfg_max_pay = 4'd2; ncap = 0;
    send(0, 4, 2, 0); send(1, 4, 2, 0); send(2, 4, 2, 0);
    wait_idle(); parse();
    begin
      int bad;
      bad = (nh == 6) ? 0 : 1;
      for (int h = 0; h < 5; h++) if (hsrc[h] == hsrc[h+1]) bad++;
      for (int h = 0; h < 3; h++) if (hsrc[h] != hsrc[h+3]) bad++;
      chk(bad == 0, "R7 rotation", bad, 0);
    end

    // R9: limit changed during a packet
    cfg_max_pay = 4'd4; ncap = 0;
    send(0, 8, 1, 0);
    while (ncap < 1) @(negedge clk);
    cfg_max_pay = 4'd2;
    wait_idle(); parse();
    chk(nh == 3 && hlen[0] == 4 && hlen[1] == 2 && hlen[2] == 2,
        "R9 first packet keeps old limit", hlen[0], 4);

    // R8: back-pressure on the link
    bp_mode = 1'b1; cfg_max_pay = 4'd3; ncap = 0;
    send(3, 10, 1, 0);
    repeat (3) @(posedge clk);
    while (busy[3]) @(posedge clk);
    repeat (60) @(posedge clk);
    bp_mode = 1'b0;
    repeat (5) @(posedge clk);
    parse();
    chk(nh == 4 && hlen[3] == 1 && pay_err == 0, "R8 data intact under stall", pay_err, 0);
    chk(stall_err == 0, "R8 output held while stalled", stall_err, 0);
    chk(ready_err == 0, "R8 ready only for owner", ready_err, 0);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

endmodule